// File: doc/BRIEF.md
# Raster Video Timing Register Bank

This block holds the software-visible settings of a raster video controller. These settings are the horizontal and vertical timing parameters, the frame base address, the row pitch and the pixel clock divider. A host reaches the bank over a simple 32-bit read/write bus that carries a byte offset and an access size. Registers sit on a 16-byte stride, and a 512-byte window of them repeats across a 4 KB decode. Host data is stored little-endian, so every write is byte-swapped and then trimmed to the width and alignment that the target register implements.

The display is turned on or off through a test register, using a strobed handshake. Software toggles a strobe bit three times while the payload holds steady. The enable state changes only when the payload's disable bit differs from the last value that was accepted. The bank also drives three monitor-sense lines and reports a 3-bit monitor ID. It keeps a vertical-blank status and an interrupt-enable pair, and raises an interrupt request while the display is on. While the display is running, any write that changes the display geometry pulses a one-cycle reconfigure output, which tells the downstream timing generator to reload.

The bus is a plain register port without back-pressure. A write takes effect at the clock edge on which `bus_wr_i` is sampled high. A read is accepted on the edge where `bus_rd_i` is high, and its data is presented one cycle later together with `bus_rvalid_o`. No data stream flows through the block, so it has no valid/ready interface.

Top module: `vid_timing_regs`

## Requirements
- R1: The register index is `bus_addr_i[8:4]`. Address bits 11:9 and 3:0 do not select a register, so the bank aliases every 512 bytes across a 4 KB window.
- R2: A write stores `swap(bus_wdata_i)`, where swap reverses the four bytes. Timing indices 0x01–0x10 keep 12 bits, except index 0x08, which keeps 10 bits, and index 0x0E, which keeps 8 bits. Parameter k is driven on `timing_o[(k-1)*12 +: 12]`.
- R3: Index 0x13 keeps the bits of mask 0x3FFFE0 and drives `fb_base_o`. Index 0x14 keeps mask 0x7FE0 and drives `row_pitch_o`. Index 0x17 keeps 2 bits and drives `clk_div_o`. Index 0x19 keeps 4 bits as the interrupt enable. Each register reads back its masked value.
- R4: A read returns its data on `bus_rdata_o` one cycle after it is accepted, with `bus_rvalid_o` high for that single cycle. Let V be the 32-bit register value and b[k] = V[8k+7:8k]. A size-4 read (or any size code other than 1 or 2) returns {b0,b1,b2,b3}. A size-1 read returns {24'b0, b[addr[1:0]]}. A size-2 read returns {16'b0, b[o], b[o+1]}, where o = {addr[1],0}.
- R5: Indices 0x00, 0x11, 0x16, 0x18 and 0x1B–0x1F read as zero. Writes to them, and to index 0x1A, change nothing that can be observed.
- R6: The test register (index 0x12) keeps 11 bits and reads back its last stored value. It resets to 0. A write that equals the stored value is ignored. A write that changes bit 10 stores the value and clears a toggle counter. Any other changing write stores the value and advances the counter, which saturates at 3. Bit 3 serves as the strobe.
- R7: When a changing write leaves the counter at 3 and its bit 10 differs from the last accepted value (reset 0x433), `disp_en_o` becomes the inverse of bit 10 and that write becomes the accepted value. `disp_en_o` resets to 0.
- R8: A write to index 0x15 drives `sense_o` from data bits 5:3. A read of index 0x15 returns `mon_id_i` in bits 8:6 and zeros elsewhere.
- R9: Status (index 0x1A) bits 3:2 are both 1 exactly one cycle after `vbl_i` is sampled high, and are 0 otherwise. Bits 1:0 read 0.
- R10: `irq_o` is high exactly when status bit 2, interrupt-enable bit 2 and `disp_en_o` are all high.
- R11: A write to an index among 0x01–0x10, 0x13, 0x14 or 0x17 while `disp_en_o` is high makes `reconf_o` high for the one cycle after that write. Otherwise `reconf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe (full word) |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte offset in the 4 KB window |
| bus_size_i | input | 3 | Read access size in bytes |
| bus_wdata_i | input | 32 | Write data, host byte order |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| bus_rvalid_o | output | 1 | Read data valid |
| vbl_i | input | 1 | Vertical blank level |
| mon_id_i | input | 3 | Monitor ID lines |
| sense_o | output | 3 | Monitor sense drive |
| timing_o | output | 192 | Sixteen 12-bit timing parameters |
| fb_base_o | output | 22 | Frame base address |
| row_pitch_o | output | 15 | Row pitch in bytes |
| clk_div_o | output | 2 | Pixel clock divide count |
| disp_en_o | output | 1 | Display enabled |
| reconf_o | output | 1 | One-cycle reload pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register result is due at the clock edge that samples the write. The bench therefore drives on falling edges and checks the outputs and `reconf_o` at the next falling edge. Read data and `bus_rvalid_o` come one edge after the read is accepted, so the bench samples them at the falling edge that follows the strobe. The vertical-blank status, and with it `irq_o`, trails `vbl_i` by one register stage; the bench checks it one full cycle after changing the input. The display enable is checked after each individual write of the strobe sequence, so a commit that comes early or late shows up as a mismatch.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int IDX_W     = 5;
  localparam int NUM_TIM   = 16;
  localparam int TIM_W     = 12;
  localparam int TEST_W    = 11;
  localparam int BASE_W    = 22;
  localparam int PITCH_W   = 15;
  localparam int DIV_W     = 2;
  localparam int IEN_W     = 4;
  localparam int ID_W      = 3;

  localparam logic [IDX_W-1:0] IX_LINE   = 5'h00;
  localparam logic [IDX_W-1:0] IX_TIM_LO = 5'h01;
  localparam logic [IDX_W-1:0] IX_TIM_HI = 5'h10;
  localparam logic [IDX_W-1:0] IX_TEST   = 5'h12;
  localparam logic [IDX_W-1:0] IX_BASE   = 5'h13;
  localparam logic [IDX_W-1:0] IX_PITCH  = 5'h14;
  localparam logic [IDX_W-1:0] IX_SENSE  = 5'h15;
  localparam logic [IDX_W-1:0] IX_DIV    = 5'h17;
  localparam logic [IDX_W-1:0] IX_IEN    = 5'h19;
  localparam logic [IDX_W-1:0] IX_STAT   = 5'h1A;

  localparam logic [DATA_W-1:0] BASE_MASK  = 32'h003F_FFE0;
  localparam logic [DATA_W-1:0] PITCH_MASK = 32'h0000_7FE0;

  function automatic int tim_bits(input int k);
    if (k == 8)  return 10;
    if (k == 14) return 8;
    return TIM_W;
  endfunction

  function automatic logic [DATA_W-1:0] swap32(input logic [DATA_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/vtr_test_hs.sv
module vtr_test_hs #(
  parameter int          TW       = 11,
  parameter int          EN_BIT   = 10,
  parameter int          CNT_W    = 2,
  parameter logic [10:0] PREV_RST = 11'h433
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wval,
  output logic [TW-1:0] test_o,
  output logic          disp_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TW-1:0]    test_q, prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_q <= '0;
      prev_q <= PREV_RST[TW-1:0];
      cnt_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en && (wval != test_q)) begin
      test_q <= wval;
      if (wval[EN_BIT] != test_q[EN_BIT]) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nx;
        if ((cnt_nx == CNT_MAX) && (wval[EN_BIT] != prev_q[EN_BIT])) begin
          en_q   <= ~wval[EN_BIT];
          prev_q <= wval;
        end
      end
    end
  end

  assign test_o    = test_q;
  assign disp_en_o = en_q;
endmodule

// File: rtl/vtr_irq.sv
module vtr_irq #(
  parameter int IEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vbl_i,
  input  logic             disp_en,
  input  logic [IEN_W-1:0] ien,
  output logic [3:0]       status_o,
  output logic             irq_o
);
  logic vbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vbl_q <= 1'b0;
    else        vbl_q <= vbl_i;
  end

  assign status_o = {vbl_q, vbl_q, 2'b00};
  assign irq_o    = status_o[2] & ien[2] & disp_en;
endmodule

// File: rtl/vtr_rd_lane.sv
module vtr_rd_lane (
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  input  logic [2:0]  size_i,
  output logic [31:0] rdata_o
);
  logic [7:0] b [4];
  logic [1:0] o2;

  always_comb begin
    for (int k = 0; k < 4; k++) b[k] = word_i[8*k +: 8];
    o2 = {off_i[1], 1'b0};
    case (size_i)
      3'd1:    rdata_o = {24'h0, b[off_i]};
      3'd2:    rdata_o = {16'h0, b[o2], b[o2 + 2'd1]};
      default: rdata_o = {b[0], b[1], b[2], b[3]};
    endcase
  end
endmodule

// File: rtl/vid_timing_regs.sv
module vid_timing_regs
  import vtr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr_i,
  input  logic                     bus_rd_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [2:0]               bus_size_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic                     bus_rvalid_o,
  input  logic                     vbl_i,
  input  logic [ID_W-1:0]          mon_id_i,
  output logic [2:0]               sense_o,
  output logic [NUM_TIM*TIM_W-1:0] timing_o,
  output logic [BASE_W-1:0]        fb_base_o,
  output logic [PITCH_W-1:0]       row_pitch_o,
  output logic [DIV_W-1:0]         clk_div_o,
  output logic                     disp_en_o,
  output logic                     reconf_o,
  output logic                     irq_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wval;
  logic [TIM_W-1:0]  tim_q [NUM_TIM];
  logic [BASE_W-1:0] base_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [DIV_W-1:0]  div_q;
  logic [IEN_W-1:0]  ien_q;
  logic [2:0]        sense_q;
  logic [TEST_W-1:0] test_w;
  logic [3:0]        stat_w;
  logic              disp_w;
  logic              geom_hit;
  logic              reconf_q;
  logic [DATA_W-1:0] rword, rlane, rdata_q;
  logic              rvalid_q;

  assign idx  = bus_addr_i[8:4];
  assign wval = swap32(bus_wdata_i);

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    localparam int          KB   = tim_bits(g + 1);
    localparam logic [TIM_W-1:0] MSK = TIM_W'((64'd1 << KB) - 64'd1);
    always_ff @(posedge clk) begin
      if (!rst_n) tim_q[g] <= '0;
      else if (bus_wr_i && idx == IDX_W'(g + 1)) tim_q[g] <= wval[TIM_W-1:0] & MSK;
    end
    assign timing_o[g*TIM_W +: TIM_W] = tim_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      pitch_q <= '0;
      div_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
    end else if (bus_wr_i) begin
      case (idx)
        IX_BASE:  base_q  <= wval[BASE_W-1:0] & BASE_MASK[BASE_W-1:0];
        IX_PITCH: pitch_q <= wval[PITCH_W-1:0] & PITCH_MASK[PITCH_W-1:0];
        IX_DIV:   div_q   <= wval[DIV_W-1:0];
        IX_IEN:   ien_q   <= wval[IEN_W-1:0];
        IX_SENSE: sense_q <= wval[5:3];
        default: ;
      endcase
    end
  end

  vtr_test_hs #(.TW(TEST_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_i && idx == IX_TEST),
    .wval      (wval[TEST_W-1:0]),
    .test_o    (test_w),
    .disp_en_o (disp_w)
  );

  vtr_irq #(.IEN_W(IEN_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .vbl_i    (vbl_i),
    .disp_en  (disp_w),
    .ien      (ien_q),
    .status_o (stat_w),
    .irq_o    (irq_o)
  );

  assign geom_hit = (idx >= IX_TIM_LO && idx <= IX_TIM_HI) ||
                    idx == IX_BASE || idx == IX_PITCH || idx == IX_DIV;

  always_ff @(posedge clk) begin
    if (!rst_n) reconf_q <= 1'b0;
    else        reconf_q <= bus_wr_i && geom_hit && disp_w;
  end

  always_comb begin
    rword = '0;
    if (idx >= IX_TIM_LO && idx <= IX_TIM_HI) begin
      rword = DATA_W'(tim_q[idx - IX_TIM_LO]);
    end else begin
      case (idx)
        IX_TEST:  rword = DATA_W'(test_w);
        IX_BASE:  rword = DATA_W'(base_q);
        IX_PITCH: rword = DATA_W'(pitch_q);
        IX_SENSE: rword = DATA_W'({mon_id_i, 6'b0});
        IX_DIV:   rword = DATA_W'(div_q);
        IX_IEN:   rword = DATA_W'(ien_q);
        IX_STAT:  rword = DATA_W'(stat_w);
        default:  rword = '0;
      endcase
    end
  end

  vtr_rd_lane u_lane (
    .word_i  (rword),
    .off_i   (bus_addr_i[1:0]),
    .size_i  (bus_size_i),
    .rdata_o (rlane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) rdata_q <= rlane;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign sense_o      = sense_q;
  assign fb_base_o    = base_q;
  assign row_pitch_o  = pitch_q;
  assign clk_div_o    = div_q;
  assign disp_en_o    = disp_w;
  assign reconf_o     = reconf_q;
endmodule

// File: rtl/vtr_checker.sv
module vtr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [11:0] bus_addr_i,
  input logic        bus_rvalid_o,
  input logic        vbl_i,
  input logic [2:0]  sense_o,
  input logic        disp_en_o,
  input logic        reconf_o,
  input logic        irq_o
);
  AST_RVALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_i |=> bus_rvalid_o); // R4
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> !bus_rvalid_o); // R4
  AST_DISP_BY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_en_o) |-> $past(bus_wr_i && bus_addr_i[8:4] == 5'h12)); // R7
  AST_SENSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr_i) |-> $stable(sense_o)); // R8
  AST_IRQ_NEEDS_VBL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(vbl_i) && disp_en_o); // R10
  AST_RECONF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_o |-> $past(bus_wr_i && disp_en_o)); // R11
endmodule

bind vid_timing_regs vtr_checker u_vtr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rvalid_o (bus_rvalid_o),
  .vbl_i        (vbl_i),
  .sense_o      (sense_o),
  .disp_en_o    (disp_en_o),
  .reconf_o     (reconf_o),
  .irq_o        (irq_o)
);

// File: tb/vid_timing_regs_bench.sv
module vid_timing_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        vbl = 1'b0;
  logic [2:0]  mon_id = 3'd0;
  logic [2:0]  sense;
  logic [191:0] timing;
  logic [21:0] fb_base;
  logic [14:0] pitch;
  logic [1:0]  cdiv;
  logic        disp_en, reconf, irq;

  int checks = 0, fails = 0, cyc = 0;

  logic [11:0] m_tim [17];
  logic [31:0] m_base, m_pitch, m_div, m_ien, m_test;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_timing_regs u_vid_timing_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .vbl_i(vbl), .mon_id_i(mon_id), .sense_o(sense),
    .timing_o(timing), .fb_base_o(fb_base), .row_pitch_o(pitch),
    .clk_div_o(cdiv), .disp_en_o(disp_en), .reconf_o(reconf), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] tim_mask(input int k);
    if (k == 8)  return 32'h3FF;
    if (k == 14) return 32'hFF;
    return 32'hFFF;
  endfunction

  function automatic logic [31:0] lane(input logic [31:0] v, input logic [1:0] o, input logic [2:0] s);
    logic [7:0] b [4];
    for (int k = 0; k < 4; k++) b[k] = v[8*k +: 8];
    if (s == 3'd1) return {24'h0, b[o]};
    if (s == 3'd2) return {16'h0, b[{o[1], 1'b0}], b[{o[1], 1'b1}]};
    return {b[0], b[1], b[2], b[3]};
  endfunction

  function automatic logic [31:0] exp_word(input int ix);
    if (ix >= 1 && ix <= 16) return {20'h0, m_tim[ix]};
    case (ix)
      5'h12: return m_test;
      5'h13: return m_base;
      5'h14: return m_pitch;
      5'h15: return {23'h0, mon_id, 6'h0};
      5'h17: return m_div;
      5'h19: return m_ien;
      5'h1A: return vbl ? 32'hC : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] host_val);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = bswap(host_val);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a; size = s;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    chk(rvalid === 1'b1, "R4 rvalid", {31'h0, rvalid}, 32'h1);
  endtask

  task automatic model_write(input int ix, input logic [31:0] v);
    if (ix >= 1 && ix <= 16) m_tim[ix] = 12'(v & tim_mask(ix));
    else if (ix == 5'h13) m_base  = v & 32'h3FFFE0;
    else if (ix == 5'h14) m_pitch = v & 32'h7FE0;
    else if (ix == 5'h17) m_div   = v & 32'h3;
    else if (ix == 5'h19) m_ien   = v & 32'hF;
  endtask

  task automatic test_wr(input logic [10:0] v, input logic exp_en, input string tag);
    bwrite(12'h120, {21'h0, v});
    m_test = {21'h0, v};
    chk(disp_en === exp_en, tag, {31'h0, disp_en}, {31'h0, exp_en});
  endtask

  logic [31:0] d;
  int ix, hits;
  logic [31:0] v;
  logic [11:0] a;
  logic [2:0]  s;
  logic        geom;

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 17; k++) m_tim[k] = '0;
    m_base = 0; m_pitch = 0; m_div = 0; m_ien = 0; m_test = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(disp_en === 1'b0 && reconf === 1'b0 && irq === 1'b0, "R7 reset outputs",
        {29'h0, disp_en, reconf, irq}, 32'h0);
    chk(timing === '0 && fb_base === '0, "R2 reset params", fb_base, 32'h0);
    bread(12'h120, 3'd4, d);
    chk(d === 32'h0, "R6 test reset", d, 32'h0);

    // Directed masking corners
    bwrite(12'h080, 32'hFFFF_FFFF); model_write(8, 32'hFFFF_FFFF);
    chk(timing[7*12 +: 12] === 12'h3FF, "R2 index 8 width", {20'h0, timing[7*12 +: 12]}, 32'h3FF);
    bwrite(12'h0E0, 32'hFFFF_FFFF); model_write(14, 32'hFFFF_FFFF);
    chk(timing[13*12 +: 12] === 12'h0FF, "R2 index 14 width", {20'h0, timing[13*12 +: 12]}, 32'hFF);
    bwrite(12'h130, 32'hFFFF_FFFF); model_write(19, 32'hFFFF_FFFF);
    chk(fb_base === 22'h3FFFE0, "R3 base mask", {10'h0, fb_base}, 32'h3FFFE0);
    bwrite(12'h140, 32'hFFFF_FFFF); model_write(20, 32'hFFFF_FFFF);
    chk(pitch === 15'h7FE0, "R3 pitch mask", {17'h0, pitch}, 32'h7FE0);
    bwrite(12'hE10, 32'h0000_0ABC); model_write(1, 32'hABC);
    chk(timing[11:0] === 12'hABC, "R1 alias at 0xE10", {20'h0, timing[11:0]}, 32'hABC);

    // Random writes then reads, display off
    for (int n = 0; n < 150; n++) begin
      ix = $urandom_range(0, 31);
      if (ix == 5'h12 || ix == 5'h15) ix = 5'h11;
      v  = $urandom;
      a  = {3'($urandom_range(0, 7)), 5'(ix), 4'h0};
      bwrite(a, v);
      model_write(ix, v);
      chk(reconf === 1'b0, "R11 no pulse while off", {31'h0, reconf}, 32'h0);
      s = 3'($urandom_range(0, 4));
      a = {3'($urandom_range(0, 7)), 5'(ix), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      bread(a, s, d);
      chk(d === lane(exp_word(ix), a[1:0], s), $sformatf("R4 R5 R2 R3 read idx %0h", ix),
          d, lane(exp_word(ix), a[1:0], s));
    end
    for (int k = 1; k <= 16; k++)
      chk(timing[(k-1)*12 +: 12] === m_tim[k], "R2 timing output", {20'h0, timing[(k-1)*12 +: 12]}, {20'h0, m_tim[k]});
    chk(cdiv === m_div[1:0], "R3 divider output", {30'h0, cdiv}, m_div);

    // Status register writes ignored
    bwrite(12'h1A0, 32'hFFFF_FFFF);
    bread(12'h1A0, 3'd4, d);
    chk(d === 32'h0, "R5 status write ignored", d, 32'h0);

    // Handshake
    test_wr(11'h008, 1'b0, "R6 toggle 1");
    test_wr(11'h000, 1'b0, "R6 toggle 2");
    test_wr(11'h008, 1'b1, "R7 commit on toggle 3");
    bread(12'h120, 3'd4, d);
    chk(d === bswap(32'h8), "R6 test readback", d, bswap(32'h8));
    test_wr(11'h400, 1'b1, "R6 bit10 change clears");
    test_wr(11'h408, 1'b1, "R6 count 1");
    test_wr(11'h400, 1'b1, "R6 count 2");
    test_wr(11'h000, 1'b1, "R6 clear again");
    test_wr(11'h008, 1'b1, "R6 count 1b");
    test_wr(11'h008, 1'b1, "R6 equal write ignored");
    test_wr(11'h000, 1'b1, "R6 count 2b");
    test_wr(11'h008, 1'b1, "R7 same bit10 no change");
    test_wr(11'h400, 1'b1, "R6 to disable");
    test_wr(11'h408, 1'b1, "R6 d1");
    test_wr(11'h400, 1'b1, "R6 d2");
    test_wr(11'h408, 1'b0, "R7 disable commit");
    test_wr(11'h000, 1'b0, "R6 re1");
    test_wr(11'h008, 1'b0, "R6 re2");
    test_wr(11'h000, 1'b0, "R6 re3");
    test_wr(11'h008, 1'b1, "R7 re-enable");

    // Reconfigure pulses with display on
    for (int n = 0; n < 60; n++) begin
      ix = $urandom_range(1, 31);
      if (ix == 5'h12) ix = 5'h13;
      v = $urandom;
      bwrite({3'h0, 5'(ix), 4'h0}, v);
      model_write(ix, v);
      geom = (ix <= 16) || ix == 5'h13 || ix == 5'h14 || ix == 5'h17;
      chk(reconf === geom, $sformatf("R11 pulse idx %0h", ix), {31'h0, reconf}, {31'h0, geom});
      @(negedge clk);
      chk(reconf === 1'b0, "R11 single cycle", {31'h0, reconf}, 32'h0);
    end

    // Sense and monitor ID
    bwrite(12'h150, 32'h0000_0028);
    chk(sense === 3'b101, "R8 sense drive", {29'h0, sense}, 32'h5);
    mon_id = 3'd6;
    bread(12'h150, 3'd4, d);
    chk(d === bswap(32'h180), "R8 id read", d, bswap(32'h180));

    // Vertical blank and interrupt
    bwrite(12'h190, 32'h4); m_ien = 4;
    @(negedge clk); vbl = 1'b1;
    chk(irq === 1'b0, "R9 status lags vbl", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk(irq === 1'b1, "R10 irq raised", {31'h0, irq}, 32'h1);
    bread(12'h1A0, 3'd1, d);
    chk(d === 32'h0C, "R9 status bits", d, 32'h0C);
    bwrite(12'h190, 32'h8); m_ien = 8;
    chk(irq === 1'b0, "R10 enable bit2 off", {31'h0, irq}, 32'h0);
    bwrite(12'h190, 32'h4); m_ien = 4;
    test_wr(11'h400, 1'b1, "R6 off1");
    test_wr(11'h408, 1'b1, "R6 off2");
    test_wr(11'h400, 1'b1, "R6 off3");
    test_wr(11'h408, 1'b0, "R7 off commit");
    chk(irq === 1'b0, "R10 display off", {31'h0, irq}, 32'h0);
    @(negedge clk); vbl = 1'b0;
    @(negedge clk);
    bread(12'h1A0, 3'd4, d);
    chk(d === 32'h0, "R9 status clears", d, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule